// File: doc/BRIEF.md
# Sign-Dependent Reference Offset Corrector

This block sits between a sampled sinusoidal voltage reference and the comparator that closes a hysteresis-style inverter voltage loop. The comparator's filtered feedback rides on one side of the reference. The block shifts the reference toward zero by an offset. The result is that the middle of the feedback ripple, not its edge, tracks the wanted waveform. For non-negative samples the offset is subtracted. For negative samples it is added.

Two modes set the offset. In constant mode the offset is the DC-link voltage scaled by a loop constant. This is the largest value the correction ever takes. In tracking mode the offset is the DC-link voltage minus the squared reference over the DC-link voltage, times the same constant. It therefore shrinks from its zero-crossing maximum toward the waveform peaks. A sequential divider forms the quotient after an update strobe from the gate controller. Each finished offset takes effect only at the following strobe, so the comparator threshold never moves in the middle of a switching period. A strobe that arrives while the divider is still working applies the last finished offset again and starts no new work.

Top module: `ref_offset_corrector`

## Requirements
- R1: After reset the applied offset is 0, so the output is 0 during reset, and after reset and before any strobe the output equals the reference input one cycle later.
- R2: With an applied offset D, a reference sample r with sign bit clear (zero counts as positive) gives r − D, and a sample with sign bit set gives r + D. The output is registered and follows the reference input one clock later.
- R3: The output saturates to the signed range of REF_W bits: −32768 and +32767 at defaults.
- R4: In constant mode (track_i = 0) the offset is floor(vdc·k / 2^K_FRAC). Here k is an unsigned fraction with K_FRAC = 16 fractional bits, and vdc is unsigned.
- R5: In tracking mode (track_i = 1) the offset is floor((vdc² − v²)·k / (vdc·2^K_FRAC)), clipped to OFF_W bits. Here v is the reference sample present at the strobe that started the work, and the result is independent of the sign of v.
- R6: In tracking mode the offset at v = 0 equals the constant-mode value, and for |v| ≥ vdc it is 0.
- R7: In tracking mode a vdc of 0 falls back to the constant-mode value, which is 0.
- R8: The applied offset changes only at a strobe. Changes of track_i, vdc_i or k_i between strobes do not alter the output for a fixed reference.
- R9: The offset applied at an accepted strobe is the one computed from the inputs at the previous accepted strobe.
- R10: Work started by a strobe takes NUM_W + 1 cycles (49 at defaults). A strobe inside that window re-applies the last completed offset, and its input values are never used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_i | input | REF_W | Signed reference sample |
| vdc_i | input | VDC_W | Unsigned DC-link voltage measurement |
| k_i | input | K_W | Unsigned loop constant, K_FRAC fractional bits |
| track_i | input | 1 | 0 = constant offset, 1 = tracking offset |
| upd_i | input | 1 | One-cycle update strobe from the gate controller |
| mod_ref_o | output | REF_W | Signed corrected reference for the comparator |

## Verification
A wrong offset register shows at the output on the cycle after the strobe that applies it. The output is then displaced from the reference by a value other than the formula's. A divider fault or a wrong pipeline stage only appears one strobe later, because results are consumed one period late. The busy window is therefore probed with a strobe pair that is closer together than the divide time. An error in the sign or saturation path is visible within one clock of any reference sample, whatever offset is applied.

// File: rtl/ofs_pkg.sv
package ofs_pkg;

   typedef enum logic {
      OFS_CONST = 1'b0,
      OFS_TRACK = 1'b1
   } ofs_mode_e;

   localparam int OFS_REF_W_DEF  = 16;
   localparam int OFS_VDC_W_DEF  = 16;
   localparam int OFS_K_W_DEF    = 16;
   localparam int OFS_K_FRAC_DEF = 16;

endpackage

// File: rtl/ofs_div.sv
module ofs_div #(
   parameter int N_W = 48,
   parameter int D_W = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start_i,
   input  logic [N_W-1:0] num_i,
   input  logic [D_W-1:0] den_i,
   output logic           busy_o,
   output logic           done_o,
   output logic [N_W-1:0] quo_o
);

   localparam int CNT_W = $clog2(N_W + 1);

   if (N_W < 2) begin : g_bad_n
      $error("ofs_div: N_W must be at least 2");
   end
   if (D_W < 1) begin : g_bad_d
      $error("ofs_div: D_W must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [N_W-1:0]   quo_q;
   logic [D_W-1:0]   rem_q;
   logic [D_W-1:0]   den_q;
   logic             done_q;

   logic [D_W:0]     rem_sh;
   logic [D_W:0]     trial;
   logic             fits;

   // one restoring step: shift next dividend bit in, subtract if it fits
   always_comb begin
      rem_sh = {rem_q, quo_q[N_W-1]};
      trial  = rem_sh - {1'b0, den_q};
      fits   = !trial[D_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         quo_q  <= '0;
         rem_q  <= '0;
         den_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= (cnt_q == CNT_W'(1));
         if (start_i && cnt_q == '0) begin
            cnt_q <= CNT_W'(N_W);
            quo_q <= num_i;
            rem_q <= '0;
            den_q <= den_i;
         end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
            quo_q <= {quo_q[N_W-2:0], fits};
            rem_q <= fits ? trial[D_W-1:0] : rem_sh[D_W-1:0];
         end
      end
   end

   assign busy_o = (cnt_q != '0);
   assign done_o = done_q;
   assign quo_o  = quo_q;

   // R5: a finished division leaves a remainder below the divisor
   p_rem_below_den_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (rem_q < den_q));

   // R10: an accepted start always opens the busy window
   p_busy_after_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> busy_o);

endmodule

// File: rtl/ofs_calc.sv
module ofs_calc
   import ofs_pkg::*;
#(
   parameter int REF_W  = 16,
   parameter int VDC_W  = 16,
   parameter int K_W    = 16,
   parameter int K_FRAC = 16,
   parameter int OFF_W  = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start_i,
   input  logic                    track_i,
   input  logic signed [REF_W-1:0] ref_i,
   input  logic [VDC_W-1:0]        vdc_i,
   input  logic [K_W-1:0]          k_i,
   output logic [OFF_W-1:0]        off_o,
   output logic                    busy_o
);

   localparam int WIDE  = (REF_W > VDC_W) ? REF_W : VDC_W;
   localparam int SQ_W  = 2 * WIDE;
   localparam int NUM_W = SQ_W + K_W;
   localparam int FIX_W = VDC_W + K_W;
   localparam int QI_W  = NUM_W - K_FRAC;

   if (K_FRAC < 1 || K_FRAC >= FIX_W) begin : g_bad_frac
      $error("ofs_calc: K_FRAC out of range");
   end
   if (OFF_W != FIX_W - K_FRAC) begin : g_bad_off
      $error("ofs_calc: OFF_W must equal VDC_W + K_W - K_FRAC");
   end
   if (QI_W <= OFF_W) begin : g_bad_qi
      $error("ofs_calc: quotient too narrow for offset");
   end

   ofs_mode_e           mode;
   logic [REF_W-1:0]    mag;
   logic [SQ_W-1:0]     sq_v;
   logic [SQ_W-1:0]     sq_d;
   logic [SQ_W-1:0]     gap;
   logic [NUM_W-1:0]    num;
   logic [FIX_W-1:0]    fix_full;
   logic [OFF_W-1:0]    fix_off;
   logic [K_FRAC-1:0]   unused_fix_frac;
   logic [NUM_W-1:0]    quo;
   logic [QI_W-1:0]     q_int;
   logic [K_FRAC-1:0]   unused_quo_frac;
   logic [OFF_W-1:0]    q_clip;
   logic                div_busy;
   logic                div_done;
   logic                accept;
   logic                div_go;
   logic [OFF_W-1:0]    off_q;
   logic [OFF_W-1:0]    bound_q;

   assign mode = ofs_mode_e'(track_i);

   always_comb begin
      mag             = ref_i[REF_W-1] ? REF_W'(~ref_i + 1'b1) : REF_W'(ref_i);
      sq_v            = SQ_W'(mag) * SQ_W'(mag);
      sq_d            = SQ_W'(vdc_i) * SQ_W'(vdc_i);
      gap             = (sq_d > sq_v) ? (sq_d - sq_v) : '0;
      num             = NUM_W'(gap) * NUM_W'(k_i);
      fix_full        = FIX_W'(vdc_i) * FIX_W'(k_i);
      fix_off         = fix_full[FIX_W-1:K_FRAC];
      unused_fix_frac = fix_full[K_FRAC-1:0];
      q_int           = quo[NUM_W-1:K_FRAC];
      unused_quo_frac = quo[K_FRAC-1:0];
      q_clip          = (|q_int[QI_W-1:OFF_W]) ? '1 : q_int[OFF_W-1:0];
   end

   assign busy_o = div_busy | div_done;
   assign accept = start_i && !busy_o;
   assign div_go = accept && (mode == OFS_TRACK) && (vdc_i != '0);

   ofs_div #(
      .N_W (NUM_W),
      .D_W (VDC_W)
   ) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (div_go),
      .num_i   (num),
      .den_i   (vdc_i),
      .busy_o  (div_busy),
      .done_o  (div_done),
      .quo_o   (quo)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         off_q   <= '0;
         bound_q <= '0;
      end else if (accept) begin
         bound_q <= fix_off;
         if (!div_go) begin
            off_q <= fix_off;
         end
      end else if (div_done) begin
         off_q <= q_clip;
      end
   end

   assign off_o = off_q;

   // R6: a tracking result never exceeds the constant value of its own inputs
   p_track_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      div_done |=> (off_q <= bound_q));

   // R7: an accepted start with zero link voltage yields a zero offset
   p_zero_link_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && vdc_i == '0) |=> (off_q == '0));

endmodule

// File: rtl/ofs_apply.sv
module ofs_apply #(
   parameter int REF_W   = 16,
   parameter int OFF_W   = 16,
   parameter bit OUT_REG = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic signed [REF_W-1:0] ref_i,
   input  logic [OFF_W-1:0]        off_i,
   output logic signed [REF_W-1:0] out_o
);

   localparam int EXT = ((REF_W > OFF_W) ? REF_W : OFF_W) + 2;

   if (REF_W < 2) begin : g_bad_ref
      $error("ofs_apply: REF_W must be at least 2");
   end

   logic [EXT-1:0]          ref_x;
   logic [EXT-1:0]          off_x;
   logic [EXT-1:0]          res;
   logic [EXT-1:0]          top_x;
   logic [EXT-1:0]          bot_x;
   logic signed [REF_W-1:0] sat;

   always_comb begin
      ref_x = {{(EXT-REF_W){ref_i[REF_W-1]}}, ref_i};
      off_x = {{(EXT-OFF_W){1'b0}}, off_i};
      top_x = {{(EXT-REF_W+1){1'b0}}, {(REF_W-1){1'b1}}};
      bot_x = {{(EXT-REF_W+1){1'b1}}, {(REF_W-1){1'b0}}};
      res   = ref_i[REF_W-1] ? (ref_x + off_x) : (ref_x - off_x);
      if ($signed(res) > $signed(top_x)) begin
         sat = top_x[REF_W-1:0];
      end else if ($signed(res) < $signed(bot_x)) begin
         sat = bot_x[REF_W-1:0];
      end else begin
         sat = res[REF_W-1:0];
      end
   end

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_o <= '0;
         end else begin
            out_o <= sat;
         end
      end

      // R2: a non-negative sample is never pushed upward
      p_pos_half_r2: assert property (@(posedge clk) disable iff (!rst_n)
         !ref_i[REF_W-1] |=> (out_o <= $past(ref_i)));

      // R2: a negative sample is never pushed downward
      p_neg_half_r2: assert property (@(posedge clk) disable iff (!rst_n)
         ref_i[REF_W-1] |=> (out_o >= $past(ref_i)));
   end else begin : g_comb
      assign out_o = sat;
   end

endmodule

// File: rtl/ref_offset_corrector.sv
module ref_offset_corrector
   import ofs_pkg::*;
#(
   parameter int REF_W   = OFS_REF_W_DEF,
   parameter int VDC_W   = OFS_VDC_W_DEF,
   parameter int K_W     = OFS_K_W_DEF,
   parameter int K_FRAC  = OFS_K_FRAC_DEF,
   parameter bit OUT_REG = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic signed [REF_W-1:0] ref_i,
   input  logic [VDC_W-1:0]        vdc_i,
   input  logic [K_W-1:0]          k_i,
   input  logic                    track_i,
   input  logic                    upd_i,
   output logic signed [REF_W-1:0] mod_ref_o
);

   localparam int OFF_W = VDC_W + K_W - K_FRAC;

   if (OFF_W < 1) begin : g_bad_off
      $error("ref_offset_corrector: offset width must be positive");
   end

   logic [OFF_W-1:0] off_next;
   logic [OFF_W-1:0] off_app;
   logic             calc_busy;

   ofs_calc #(
      .REF_W  (REF_W),
      .VDC_W  (VDC_W),
      .K_W    (K_W),
      .K_FRAC (K_FRAC),
      .OFF_W  (OFF_W)
   ) u_calc (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (upd_i),
      .track_i (track_i),
      .ref_i   (ref_i),
      .vdc_i   (vdc_i),
      .k_i     (k_i),
      .off_o   (off_next),
      .busy_o  (calc_busy)
   );

   // applied offset: swapped in only on the strobe
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         off_app <= '0;
      end else if (upd_i) begin
         off_app <= off_next;
      end
   end

   ofs_apply #(
      .REF_W   (REF_W),
      .OFF_W   (OFF_W),
      .OUT_REG (OUT_REG)
   ) u_apply (
      .clk   (clk),
      .rst_n (rst_n),
      .ref_i (ref_i),
      .off_i (off_app),
      .out_o (mod_ref_o)
   );

   // R8: without a strobe the applied offset holds
   p_hold_offset_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_i |=> $stable(off_app));

   // R10: while busy the value handed over cannot change
   p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (calc_busy && !$past(calc_busy) && !upd_i) |=> $stable(off_next));

endmodule

// File: tb/ref_offset_corrector_test.sv
module ref_offset_corrector_test;

   localparam int CLK_PERIOD = 10;
   localparam int NV         = 10;
   localparam int SETTLE     = 60;
   localparam int WD_LIMIT   = 20000;

   // columns: mode, compute sample, vdc, k, applied sample
   localparam longint V_MODE [NV] = '{0, 0, 1, 1, 1, 1, 1, 1, 0, 1};
   localparam longint V_A    [NV] = '{5000, 0, 0, 10000, -10000, 15000, 3000, 0, 0, -20000};
   localparam longint V_VDC  [NV] = '{12000, 12000, 12000, 12000, 12000, 12000, 0, 65535, 65535, 30000};
   localparam longint V_K    [NV] = '{20480, 20480, 20480, 20480, 20480, 20480, 20480, 65535, 65535, 40000};
   localparam longint V_B    [NV] = '{8000, -8000, 1000, 10000, -10000, 200, 3000, 0, -1, -25000};

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic signed [15:0] refv = '0;
   logic [15:0]        vdc = '0;
   logic [15:0]        k = '0;
   logic               track = 1'b0;
   logic               upd = 1'b0;
   logic signed [15:0] mod_ref;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   ref_offset_corrector uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .ref_i     (refv),
      .vdc_i     (vdc),
      .k_i       (k),
      .track_i   (track),
      .upd_i     (upd),
      .mod_ref_o (mod_ref)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles == WD_LIMIT) begin
         fails = fails + 1;
         checks = checks + 1;
         $display("FAIL watchdog actual=%0d expected=<%0d cycles", cycles, WD_LIMIT);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   function automatic longint exp_off(longint md, longint v, longint vd, longint kk);
      longint d;
      longint q;
      if (md == 0 || vd == 0) return (vd * kk) >> 16;
      d = vd * vd - v * v;
      if (d < 0) d = 0;
      q = ((d * kk) / vd) >> 16;
      if (q > 65535) q = 65535;
      return q;
   endfunction

   function automatic longint exp_out(longint r, longint off);
      longint t;
      t = (r >= 0) ? r - off : r + off;
      if (t > 32767) t = 32767;
      if (t < -32768) t = -32768;
      return t;
   endfunction

   function automatic string vec_tag(int i);
      case (i)
         0:       return "R4";
         1:       return "R2";
         2, 5:    return "R6";
         6:       return "R7";
         7, 8:    return "R3";
         default: return "R5";
      endcase
   endfunction

   task automatic check(string tag, longint act, longint expv);
      checks = checks + 1;
      if (act != expv) begin
         fails = fails + 1;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   task automatic strobe();
      @(negedge clk) upd = 1'b1;
      @(negedge clk) upd = 1'b0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      longint off_a;
      longint off_c;

      // R1: reset state
      idle(3);
      check("R1", longint'(mod_ref), 0);
      @(negedge clk) rst_n = 1'b1;
      refv = 16'sd1234;
      idle(3);
      check("R1", longint'(mod_ref), 1234);

      // table walk: compute at one strobe, apply at the next
      for (int i = 0; i < NV; i++) begin
         track = V_MODE[i][0];
         vdc   = V_VDC[i][15:0];
         k     = V_K[i][15:0];
         refv  = V_A[i][15:0];
         strobe();
         idle(SETTLE);
         strobe();
         refv = V_B[i][15:0];
         idle(3);
         check(vec_tag(i), longint'(mod_ref),
               exp_out(V_B[i], exp_off(V_MODE[i], V_A[i], V_VDC[i], V_K[i])));
         idle(SETTLE);
      end

      // R6: tracking value at zero crossing matches constant value
      track = 1'b1; vdc = 16'd20000; k = 16'd30000; refv = '0;
      strobe();
      idle(SETTLE);
      strobe();
      refv = 16'sd30000;
      idle(3);
      check("R6", longint'(mod_ref), exp_out(30000, exp_off(0, 0, 20000, 30000)));
      idle(SETTLE);

      // R8: no strobe, changed controls, output unchanged
      track = 1'b0; vdc = 16'd12000; k = 16'd20480; refv = 16'sd500;
      strobe();
      idle(SETTLE);
      strobe();
      refv = 16'sd9000;
      idle(SETTLE);
      track = 1'b1; vdc = 16'd40000; k = 16'd60000;
      idle(SETTLE);
      check("R8", longint'(mod_ref), exp_out(9000, exp_off(0, 0, 12000, 20480)));

      // R10 and R9: strobe inside the busy window
      track = 1'b1; vdc = 16'd12000; k = 16'd20480; refv = 16'sd4000;
      strobe();
      idle(SETTLE);
      refv = 16'sd8000;
      strobe();
      refv = -16'sd2000;
      idle(2);
      strobe();
      refv = 16'sd5000;
      idle(3);
      off_a = exp_off(1, 4000, 12000, 20480);
      check("R10", longint'(mod_ref), exp_out(5000, off_a));
      idle(SETTLE);
      strobe();
      idle(3);
      off_c = exp_off(1, 8000, 12000, 20480);
      check("R9", longint'(mod_ref), exp_out(5000, off_c));

      // R2: negative sample with same applied offset
      refv = -16'sd5000;
      idle(3);
      check("R2", longint'(mod_ref), exp_out(-5000, off_c));

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule